// File: doc/BRIEF.md
# Size-Selectable Integer ALU with Condition Codes

This block is the integer execution unit of a 32-bit data path. Each cycle it takes an operation code, an operand size, a source operand, a destination operand and an 8-bit literal field. It produces the result combinationally in the same cycle. Operations covered are move, quick literal load, add, add-with-extend, quick add, subtract, negate, negate-with-extend, clear, sign extension and half-word exchange. Two address-destination variants, move and add, run at the full 32 bits and leave the condition codes untouched.

A five-bit condition code register sits beside the datapath and holds extend, negative, zero, overflow and carry. It is written at the clock edge when the flag-write enable is high, and each operation class has its own rule for it. The extend bit stays in place across moves and clears. It feeds back into the extend variants, so a multiword sum or negation can be built one slice at a time. The zero bit can only be cleared along such a chain, which lets a whole-chain zero test survive. Byte and word operations replace only the low bits of the destination and pass its upper bits through.

Top module: `int_alu`

## Requirements
- R1: Size code 00 selects byte, 01 selects word, 10 and 11 select long. For byte or word size, every operation except quick load (2), swap (12), address move (1) and address add (4) places its value in the low 8 or 16 bits of the result, and the upper result bits equal the destination's upper bits.
- R2: Move (op 0) places the source's low size bits in the result. It sets N to the result's top bit at that size and Z to whether the result is zero at that size, clears V and C, and keeps X. The ccr_o layout is X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R3: Add (op 3) computes destination plus source, subtract (op 7) computes destination minus source, and negate (op 8) computes zero minus destination. V is signed overflow at the selected size, C is carry or borrow, X takes the value of C, and N and Z are taken at that size.
- R4: Add-with-extend (op 6) computes destination plus source plus X. X and C both take the carry out of the top bit of the size. Z is cleared when the result at size is nonzero and is otherwise unchanged. N and V follow R3.
- R5: Negate-with-extend (op 9) computes zero minus destination minus X. Its flags follow the rule of R4, with borrow in place of carry.
- R6: Quick add (op 5) adds a literal from imm_i[2:0] to the destination, where 000 means 8 and any other code means its own value. imm_i[7:3] is ignored. Flags follow R3.
- R7: Quick load (op 11 excepted; op 2) writes all 32 bits with imm_i sign-extended, for any size. It sets N and Z from the 32-bit result, clears V and C, and keeps X.
- R8: Sign extension (op 11) at word size copies bit 7 into bits 15:8. At long size it copies bit 15 into bits 31:16. N and Z are taken at that size, V and C are cleared, and X is kept. At byte size the result equals the destination and the flags do not change.
- R9: Swap (op 12) exchanges the two 16-bit halves of the destination, for any size. N and Z are taken at 32 bits, V and C are cleared, and X is kept.
- R10: Address move (op 1) returns the full 32-bit source, and address add (op 4) returns the full 32-bit sum of destination and source, for any size. Neither changes any flag.
- R11: Clear (op 10) zeroes the low size bits, sets Z, clears N, V and C, and keeps X.
- R12: With flag_we_i low the flags do not change. Op codes 13 to 15 return the destination and change no flag.
- R13: After reset, ccr_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| imm_i | input | 8 | Literal field for quick load and quick add |
| flag_we_i | input | 1 | Enables the condition code update at the clock edge |
| result_o | output | 32 | Combinational result |
| ccr_o | output | 5 | Condition codes {X,N,Z,V,C} |

## Verification
Carries and overflows are placed at bit 8 and bit 16 as well as bit 32. A design that took carry or overflow from the wrong bit position would report wrong C, X or V at byte and word size, and one that leaked the size mask would corrupt the destination's upper bits. The extend chains are run with X both set and clear, and with zero and nonzero slices. A design that recomputed Z outright would lose a chained zero, and one that ignored X would be off by one. Further cases cover the quick-add code 000, negation of the most negative byte, and byte-size sign extension. The address-destination ops, the disabled flag write and the reserved codes are each shown to leave ccr_o exactly as it was; a design that still updated flags there would show a changed ccr_o.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOVE  = 4'd0,
    OP_MOVEA = 4'd1,
    OP_LDQ   = 4'd2,
    OP_ADD   = 4'd3,
    OP_ADDA  = 4'd4,
    OP_ADDQ  = 4'd5,
    OP_ADDX  = 4'd6,
    OP_SUB   = 4'd7,
    OP_NEG   = 4'd8,
    OP_NEGX  = 4'd9,
    OP_CLR   = 4'd10,
    OP_SEXT  = 4'd11,
    OP_SWAP  = 4'd12
  } alu_op_e;

  // how an operation treats the condition codes
  typedef enum logic [1:0] {
    FL_KEEP  = 2'd0,
    FL_ARITH = 2'd1,
    FL_CHAIN = 2'd2,
    FL_LOGIC = 2'd3
  } flag_cls_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  localparam int CC_X = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;
  localparam int CCW  = 5;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import int_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);

  localparam int NSZ = 3;

  logic [DW-1:0]  sum_k  [NSZ];
  logic [NSZ-1:0] cout_k;
  logic [NSZ-1:0] ovf_k;

  // one adder slice per operand size; carries are taken at each slice's top
  for (genvar k = 0; k < NSZ; k++) begin : g_slice
    localparam int W = DW >> (NSZ - 1 - k);
    logic [W-1:0] b_eff;
    logic         c_in;
    logic [W:0]   ext;

    assign b_eff = sub_i ? ~b_i[W-1:0] : b_i[W-1:0];
    assign c_in  = cin_i ^ sub_i;
    assign ext   = {1'b0, a_i[W-1:0]} + {1'b0, b_eff} + {{W{1'b0}}, c_in};

    assign cout_k[k] = ext[W] ^ sub_i;
    assign ovf_k[k]  = (a_i[W-1] == b_eff[W-1]) && (ext[W-1] != a_i[W-1]);
    if (W < DW) begin : g_pad
      assign sum_k[k] = {{(DW-W){1'b0}}, ext[W-1:0]};
    end else begin : g_full
      assign sum_k[k] = ext[W-1:0];
    end
  end

  always_comb begin
    case (size_i)
      SZ_BYTE: begin sum_o = sum_k[0]; cout_o = cout_k[0]; ovf_o = ovf_k[0]; end
      SZ_WORD: begin sum_o = sum_k[1]; cout_o = cout_k[1]; ovf_o = ovf_k[1]; end
      default: begin sum_o = sum_k[2]; cout_o = cout_k[2]; ovf_o = ovf_k[2]; end
    endcase
  end

endmodule

// File: rtl/alu_unary.sv
module alu_unary
  import int_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic [7:0]    imm_i,
  output logic [DW-1:0] res_o,
  output logic          sext_bad_o
);

  localparam int BW = DW / 4;
  localparam int HW = DW / 2;

  logic [DW-1:0] mask;
  logic [DW-1:0] sext_val;

  always_comb begin
    case (size_i)
      SZ_BYTE: mask = {{(DW-BW){1'b0}}, {BW{1'b1}}};
      SZ_WORD: mask = {{(DW-HW){1'b0}}, {HW{1'b1}}};
      default: mask = {DW{1'b1}};
    endcase
  end

  always_comb begin
    case (size_i)
      SZ_WORD: sext_val = {dst_i[DW-1:HW], {(HW-BW){dst_i[BW-1]}}, dst_i[BW-1:0]};
      default: sext_val = {{(DW-HW){dst_i[HW-1]}}, dst_i[HW-1:0]};
    endcase
  end

  assign sext_bad_o = (op_i == OP_SEXT) && (size_i == SZ_BYTE);

  always_comb begin
    case (op_i)
      OP_MOVE:  res_o = (dst_i & ~mask) | (src_i & mask);
      OP_MOVEA: res_o = src_i;
      OP_LDQ:   res_o = {{(DW-8){imm_i[7]}}, imm_i};
      OP_CLR:   res_o = dst_i & ~mask;
      OP_SEXT:  res_o = sext_bad_o ? dst_i : sext_val;
      OP_SWAP:  res_o = {dst_i[HW-1:0], dst_i[DW-1:HW]};
      default:  res_o = dst_i;
    endcase
  end

endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import int_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  flag_cls_e      cls_i,
  input  logic           n_i,
  input  logic           z_i,
  input  logic           v_i,
  input  logic           c_i,
  output logic [CCW-1:0] ccr_o
);

  logic [CCW-1:0] ccr_q;
  logic [CCW-1:0] ccr_d;
  logic           upd;

  always_comb begin
    ccr_d = ccr_q;
    case (cls_i)
      FL_ARITH: begin
        ccr_d[CC_X] = c_i;
        ccr_d[CC_N] = n_i;
        ccr_d[CC_Z] = z_i;
        ccr_d[CC_V] = v_i;
        ccr_d[CC_C] = c_i;
      end
      FL_CHAIN: begin
        ccr_d[CC_X] = c_i;
        ccr_d[CC_N] = n_i;
        ccr_d[CC_Z] = z_i & ccr_q[CC_Z];
        ccr_d[CC_V] = v_i;
        ccr_d[CC_C] = c_i;
      end
      FL_LOGIC: begin
        ccr_d[CC_N] = n_i;
        ccr_d[CC_Z] = z_i;
        ccr_d[CC_V] = 1'b0;
        ccr_d[CC_C] = 1'b0;
      end
      default: ccr_d = ccr_q;
    endcase
  end

  assign upd = we_i && (cls_i != FL_KEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q <= '0;
    end else if (upd) begin
      ccr_q <= ccr_d;
    end
  end

  assign ccr_o = ccr_q;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     op_i,
  input  logic [1:0]     size_i,
  input  logic [DW-1:0]  src_i,
  input  logic [DW-1:0]  dst_i,
  input  logic [7:0]     imm_i,
  input  logic           flag_we_i,
  output logic [DW-1:0]  result_o,
  output logic [CCW-1:0] ccr_o
);

  localparam int BW = DW / 4;
  localparam int HW = DW / 2;
  localparam int QW = 3;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  // adder operand steering
  logic [DW-1:0] as_a, as_b, as_sum;
  logic          as_cin, as_sub, as_cout, as_ovf;
  logic [DW-1:0] quick_lit;
  logic          x_cur;

  assign x_cur     = ccr_o[CC_X];
  assign quick_lit = (imm_i[QW-1:0] == '0) ? DW'(8) : {{(DW-QW){1'b0}}, imm_i[QW-1:0]};

  always_comb begin
    as_a   = dst_i;
    as_b   = src_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op_i)
      OP_ADDX: as_cin = x_cur;
      OP_ADDQ: as_b   = quick_lit;
      OP_SUB:  as_sub = 1'b1;
      OP_NEG:  begin as_a = '0; as_b = dst_i; as_sub = 1'b1; end
      OP_NEGX: begin as_a = '0; as_b = dst_i; as_sub = 1'b1; as_cin = x_cur; end
      default: ;
    endcase
  end

  alu_addsub #(.DW(DW)) i_addsub (
    .a_i    (as_a),
    .b_i    (as_b),
    .cin_i  (as_cin),
    .sub_i  (as_sub),
    .size_i (size_i),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf)
  );

  logic [DW-1:0] un_res;
  logic          sext_bad;

  alu_unary #(.DW(DW)) i_unary (
    .op_i       (op_i),
    .size_i     (size_i),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .imm_i      (imm_i),
    .res_o      (un_res),
    .sext_bad_o (sext_bad)
  );

  // size mask and merge of the adder value into the destination
  logic [DW-1:0] size_mask;
  logic [DW-1:0] arith_res;
  logic          is_arith;
  logic          is_chain;

  always_comb begin
    case (size_i)
      SZ_BYTE: size_mask = {{(DW-BW){1'b0}}, {BW{1'b1}}};
      SZ_WORD: size_mask = {{(DW-HW){1'b0}}, {HW{1'b1}}};
      default: size_mask = {DW{1'b1}};
    endcase
  end

  assign arith_res = (dst_i & ~size_mask) | (as_sum & size_mask);
  assign is_chain  = (op_i == OP_ADDX) || (op_i == OP_NEGX);
  assign is_arith  = (op_i == OP_ADD) || (op_i == OP_ADDQ) ||
                     (op_i == OP_SUB) || (op_i == OP_NEG) || is_chain;

  always_comb begin
    if (is_arith) begin
      result_o = arith_res;
    end else if (op_i == OP_ADDA) begin
      result_o = dst_i + src_i;
    end else begin
      result_o = un_res;
    end
  end

  // flag class and the size at which N and Z are read
  flag_cls_e  cls;
  logic [1:0] flag_sz;

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADDQ, OP_SUB, OP_NEG:       cls = FL_ARITH;
      OP_ADDX, OP_NEGX:                      cls = FL_CHAIN;
      OP_MOVE, OP_LDQ, OP_CLR, OP_SWAP:      cls = FL_LOGIC;
      OP_SEXT:                               cls = sext_bad ? FL_KEEP : FL_LOGIC;
      default:                               cls = FL_KEEP;
    endcase
  end

  assign flag_sz = ((op_i == OP_LDQ) || (op_i == OP_SWAP)) ? SZ_LONG : size_i;

  logic res_n, res_z;

  always_comb begin
    case (flag_sz)
      SZ_BYTE: begin res_n = result_o[BW-1]; res_z = (result_o[BW-1:0] == '0); end
      SZ_WORD: begin res_n = result_o[HW-1]; res_z = (result_o[HW-1:0] == '0); end
      default: begin res_n = result_o[DW-1]; res_z = (result_o == '0); end
    endcase
  end

  alu_ccr i_ccr (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .we_i   (flag_we_i),
    .cls_i  (cls),
    .n_i    (res_n),
    .z_i    (res_z),
    .v_i    (as_ovf),
    .c_i    (as_cout),
    .ccr_o  (ccr_o)
  );

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [3:0]     op,
  input logic [DW-1:0]  dst,
  input logic [7:0]     imm,
  input logic           flag_we,
  input logic [DW-1:0]  result,
  input logic [CCW-1:0] ccr
);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(ccr));

  p_addr_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == OP_MOVEA || op == OP_ADDA)) |=> $stable(ccr));

  p_x_eq_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == OP_ADD || op == OP_SUB || op == OP_NEG || op == OP_ADDQ))
    |=> (ccr[CC_X] == ccr[CC_C]));

  p_chain_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == OP_ADDX || op == OP_NEGX) && result[7:0] != 8'h00)
    |=> !ccr[CC_Z]);

  p_clr_x_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op == OP_CLR) |=> (ccr[CC_X] == $past(ccr[CC_X]) && ccr[CC_Z]));

  p_ldq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LDQ) |-> (result == {{(DW-8){imm[7]}}, imm}));

  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SWAP) |-> (result == {dst[DW/2-1:0], dst[DW-1:DW/2]}));

endmodule

bind int_alu int_alu_chk #(.DW(DW)) i_chk (
  .clk     (clk_i),
  .rst_n   (rst_sync_n),
  .op      (op_i),
  .dst     (dst_i),
  .imm     (imm_i),
  .flag_we (flag_we_i),
  .result  (result_o),
  .ccr     (ccr_o)
);

// File: tb/test_int_alu.sv
module test_int_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [1:0]  size;
  logic [31:0] src, dst;
  logic [7:0]  imm;
  logic        we;
  logic [31:0] result;
  logic [4:0]  ccr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  int_alu i_int_alu (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_i      (op),
    .size_i    (size),
    .src_i     (src),
    .dst_i     (dst),
    .imm_i     (imm),
    .flag_we_i (we),
    .result_o  (result),
    .ccr_o     (ccr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one operation, check the result mid-cycle and the flags after the edge
  task automatic run(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] s,
                     input logic [31:0] d, input logic [7:0] im, input logic w,
                     input logic [31:0] er, input logic [4:0] ec, input string tag);
    @(negedge clk);
    op = o; size = sz; src = s; dst = d; imm = im; we = w;
    #2;
    check({tag, " result"}, result, er);
    @(posedge clk);
    #2;
    check({tag, " ccr"}, {27'd0, ccr}, {27'd0, ec});
  endtask

  // put X to a known value through a long add whose result is zero
  task automatic set_x(input logic x);
    if (x) run(4'd3, 2'b10, 32'h1, 32'hFFFFFFFF, 8'h0, 1'b1, 32'h0, 5'b10101, "setup X=1");
    else   run(4'd3, 2'b10, 32'h0, 32'h0,        8'h0, 1'b1, 32'h0, 5'b00100, "setup X=0");
  endtask

  task automatic t_reset();
    check("R13 ccr after reset", {27'd0, ccr}, 32'h0);
  endtask

  task automatic t_move();
    set_x(1'b1);
    run(4'd0, 2'b00, 32'h00000080, 32'h12345678, 8'h0, 1'b1, 32'h12345680, 5'b11000, "R2 R1 move byte");
    run(4'd0, 2'b01, 32'h00000000, 32'hFFFFFFFF, 8'h0, 1'b1, 32'hFFFF0000, 5'b10100, "R2 R1 move word zero");
  endtask

  task automatic t_add();
    set_x(1'b0);
    run(4'd3, 2'b10, 32'h00000001, 32'h7FFFFFFF, 8'h0, 1'b1, 32'h80000000, 5'b01010, "R3 add long overflow");
    run(4'd3, 2'b00, 32'h00000001, 32'hAABBCCFF, 8'h0, 1'b1, 32'hAABBCC00, 5'b10101, "R3 R1 add byte carry");
    run(4'd3, 2'b01, 32'h00000001, 32'h00007FFF, 8'h0, 1'b1, 32'h00008000, 5'b01010, "R3 add word overflow");
    run(4'd7, 2'b01, 32'h00000001, 32'h11110000, 8'h0, 1'b1, 32'h1111FFFF, 5'b11001, "R3 sub word borrow");
    run(4'd7, 2'b10, 32'h00000005, 32'h00000005, 8'h0, 1'b1, 32'h00000000, 5'b00100, "R3 sub long zero");
    run(4'd8, 2'b00, 32'h0,        32'h00000080, 8'h0, 1'b1, 32'h00000080, 5'b11011, "R3 neg byte min");
    run(4'd8, 2'b10, 32'h0,        32'h00000000, 8'h0, 1'b1, 32'h00000000, 5'b00100, "R3 neg long zero");
  endtask

  task automatic t_addx();
    set_x(1'b1);
    run(4'd6, 2'b10, 32'h0,  32'hFFFFFFFF, 8'h0, 1'b1, 32'h00000000, 5'b10101, "R4 addx long carry keeps Z");
    run(4'd6, 2'b00, 32'h1,  32'h120000FE, 8'h0, 1'b1, 32'h12000000, 5'b10101, "R4 addx byte carry keeps Z");
    run(4'd6, 2'b00, 32'h0,  32'h00000000, 8'h0, 1'b1, 32'h00000001, 5'b00000, "R4 addx nonzero clears Z");
    run(4'd6, 2'b10, 32'h0,  32'h00000000, 8'h0, 1'b1, 32'h00000000, 5'b00000, "R4 addx zero leaves Z clear");
  endtask

  task automatic t_negx();
    set_x(1'b1);
    run(4'd9, 2'b00, 32'h0, 32'h12345600, 8'h0, 1'b1, 32'h123456FF, 5'b11001, "R5 negx byte with X");
    set_x(1'b0);
    run(4'd9, 2'b10, 32'h0, 32'h00000000, 8'h0, 1'b1, 32'h00000000, 5'b00100, "R5 negx zero keeps Z");
  endtask

  task automatic t_addq();
    set_x(1'b1);
    run(4'd5, 2'b10, 32'h0, 32'h00000010, 8'h00, 1'b1, 32'h00000018, 5'b00000, "R6 addq code 000 is 8");
    run(4'd5, 2'b00, 32'h0, 32'h000000FF, 8'h03, 1'b1, 32'h00000002, 5'b10001, "R6 addq byte carry");
    run(4'd5, 2'b10, 32'h0, 32'h00000001, 8'hF9, 1'b1, 32'h00000002, 5'b00000, "R6 addq upper imm ignored");
  endtask

  task automatic t_ldq();
    set_x(1'b1);
    run(4'd2, 2'b00, 32'h0, 32'h12345678, 8'hFD, 1'b1, 32'hFFFFFFFD, 5'b11000, "R7 quick load -3");
    run(4'd2, 2'b01, 32'h0, 32'hFFFFFFFF, 8'h7F, 1'b1, 32'h0000007F, 5'b10000, "R7 quick load +127");
    run(4'd2, 2'b10, 32'h0, 32'hFFFFFFFF, 8'h00, 1'b1, 32'h00000000, 5'b10100, "R7 quick load zero");
  endtask

  task automatic t_sext();
    set_x(1'b1);
    run(4'd11, 2'b01, 32'h0, 32'hABCD0080, 8'h0, 1'b1, 32'hABCDFF80, 5'b11000, "R8 sext word");
    run(4'd11, 2'b10, 32'h0, 32'h00008000, 8'h0, 1'b1, 32'hFFFF8000, 5'b11000, "R8 sext long");
    run(4'd11, 2'b01, 32'h0, 32'h0000007F, 8'h0, 1'b1, 32'h0000007F, 5'b10000, "R8 sext word positive");
    run(4'd11, 2'b00, 32'h0, 32'h12345678, 8'h0, 1'b1, 32'h12345678, 5'b10000, "R8 sext byte no effect");
  endtask

  task automatic t_swap_clr();
    set_x(1'b0);
    run(4'd12, 2'b00, 32'h0, 32'h12345678, 8'h0, 1'b1, 32'h56781234, 5'b00000, "R9 swap");
    run(4'd12, 2'b10, 32'h0, 32'h00000000, 8'h0, 1'b1, 32'h00000000, 5'b00100, "R9 swap zero");
    set_x(1'b1);
    run(4'd10, 2'b01, 32'h0, 32'hDEADBEEF, 8'h0, 1'b1, 32'hDEAD0000, 5'b10100, "R11 clear word");
  endtask

  task automatic t_addr_hold();
    set_x(1'b1);
    run(4'd1, 2'b00, 32'hCAFEBABE, 32'h00000001, 8'h0, 1'b1, 32'hCAFEBABE, 5'b10101, "R10 address move");
    run(4'd4, 2'b01, 32'h00010000, 32'hFFFFFFFF, 8'h0, 1'b1, 32'h0000FFFF, 5'b10101, "R10 address add");
    set_x(1'b0);
    run(4'd3, 2'b10, 32'h00000001, 32'h7FFFFFFF, 8'h0, 1'b0, 32'h80000000, 5'b00100, "R12 write disabled");
    run(4'd13, 2'b10, 32'h00000011, 32'h00000055, 8'h0, 1'b1, 32'h00000055, 5'b00100, "R12 reserved op");
    run(4'd15, 2'b00, 32'hFFFFFFFF, 32'h000000AA, 8'h0, 1'b1, 32'h000000AA, 5'b00100, "R12 reserved op 15");
  endtask

  initial begin
    rst_n = 1'b0;
    op = 4'd0; size = 2'b10; src = '0; dst = '0; imm = '0; we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_move();
    t_add();
    t_addx();
    t_negx();
    t_addq();
    t_ldq();
    t_sext();
    t_swap_clr();
    t_addr_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule